// File: doc/BRIEF.md
# Address-Table Violation Capture Unit

The unit sits next to the address lookup path of a switch. It records table violations that the lookup path reports and passes them to a host processor. There are four violation kinds: age-out, member, miss and table-full. Each kind arrives as a one-cycle strobe, together with the source port ID of the offending frame, its port vector and its MAC address. The first violation is latched while the unit is idle with nothing pending. The unit then raises an interrupt.

The host services the interrupt with a get-and-clear command. The command returns the latched details through the same result registers that normal table commands use: a flag field in the operation view, the source port ID in the entry-state field of the data view, the port vector, and the MAC address. The command also clears the pending condition. Violations that arrive while one is already pending are dropped, and a sticky overflow bit records that this happened.

Top module: `vio_capture`

## Requirements
- R1: After reset, irq, busy and overflow are low, and the flag, port ID, port vector and MAC outputs are all zero.
- R2: A violation strobe that arrives while nothing is pending is latched at the next clock edge, and irq is high from that edge on.
- R3: The flag bit for each kind is at a fixed position in vioStb and in resFlags: bit 0 is age-out, bit 1 is member, bit 2 is miss and bit 3 is table-full. Strobes that arrive in the same cycle are all latched together.
- R4: When cmdStart is high, cmdOp equals the get-and-clear code (default 5) and busy is low, busy goes high for exactly one cycle. At the edge that ends busy, resFlags, resSpid, resPortVec and resMac take the latched flags, source port ID, port vector and MAC address.
- R5: irq goes low in the cycle after get-and-clear completes. It stays low until a new violation strobe arrives.
- R6: A violation that arrives while one is pending is dropped, and the latched details stay unchanged. Overflow goes high and stays high until reset.
- R7: A get-and-clear issued with nothing pending returns zero on every result field.
- R8: A command with any code other than get-and-clear is ignored: busy stays low, and irq and the result fields do not change.
- R9: A violation that arrives in the cycle in which get-and-clear completes is latched as the new pending violation, and overflow is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vioStb | input | 4 | Violation strobes, one bit per kind |
| vioSpid | input | SPID_W (4) | Source port ID of the violating frame |
| vioPortVec | input | NPORT (11) | Port vector associated with the violation |
| vioMac | input | MAC_W (48) | MAC address that caused the violation |
| cmdStart | input | 1 | Host command request |
| cmdOp | input | OP_W (3) | Host command code |
| busy | output | 1 | Command in progress |
| resFlags | output | 4 | Violation flags in the operation view |
| resSpid | output | SPID_W (4) | Source port ID in the entry-state field |
| resPortVec | output | NPORT (11) | Port vector field |
| resMac | output | MAC_W (48) | MAC result register |
| irq | output | 1 | Violation pending interrupt |
| overflow | output | 1 | Sticky dropped-violation indicator |

## Verification
The first stimulus is a single-kind strobe, followed by a combined strobe of three kinds in one cycle. These two cases tell apart per-kind flag placement and merging of kinds. A second violation sent while the first is still pending must leave the first one's details in place and set overflow; if the unit overwrote instead of dropping, the results would differ. Three further cases cover the command edges: a get-and-clear with nothing pending, a command with a foreign code, and a strobe placed exactly in the completion cycle. These separate clearing from ignoring, and handover from overflow.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  localparam int unsigned KINDS = 4;

  typedef struct packed {
    logic loadCap;
    logic copyOut;
    logic copyValid;
  } vcapCtl_t;
endpackage

// File: rtl/vcap_ctrl.sv
module vcap_ctrl
  import vcap_pkg::*;
#(
  parameter int unsigned OP_W = 3,
  parameter logic [OP_W-1:0] GET_CLR_OP = 3'd5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            vioAny,
  input  logic            cmdStart,
  input  logic [OP_W-1:0] cmdOp,
  output vcapCtl_t        ctl,
  output logic            busy,
  output logic            irq,
  output logic            overflow
);
  logic pending;
  logic startGc;

  assign startGc = cmdStart && (cmdOp == GET_CLR_OP) && !busy;

  always_comb begin
    ctl.loadCap   = vioAny && (!pending || busy);
    ctl.copyOut   = busy;
    ctl.copyValid = pending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      pending  <= 1'b0;
      overflow <= 1'b0;
    end else begin
      busy <= startGc;
      if (busy) pending <= vioAny;
      else if (vioAny) pending <= 1'b1;
      if (vioAny && pending && !busy) overflow <= 1'b1;
    end
  end

  assign irq = pending;

  a_r4_busy_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);
  a_r5_irq_drops: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !vioAny) |=> !irq);
  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  a_r8_foreign_op_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(cmdStart && cmdOp == GET_CLR_OP)) |=> !busy);
  a_r2_irq_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!irq && !vioAny) |=> !irq);
endmodule

// File: rtl/vcap_dpath.sv
module vcap_dpath
  import vcap_pkg::*;
#(
  parameter int unsigned SPID_W = 4,
  parameter int unsigned NPORT  = 11,
  parameter int unsigned MAC_W  = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  vcapCtl_t          ctl,
  input  logic [KINDS-1:0]  vioStb,
  input  logic [SPID_W-1:0] vioSpid,
  input  logic [NPORT-1:0]  vioPortVec,
  input  logic [MAC_W-1:0]  vioMac,
  output logic [KINDS-1:0]  resFlags,
  output logic [SPID_W-1:0] resSpid,
  output logic [NPORT-1:0]  resPortVec,
  output logic [MAC_W-1:0]  resMac
);
  logic [KINDS-1:0]  capFlags;
  logic [SPID_W-1:0] capSpid;
  logic [NPORT-1:0]  capPortVec;
  logic [MAC_W-1:0]  capMac;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capFlags   <= '0;
      capSpid    <= '0;
      capPortVec <= '0;
      capMac     <= '0;
    end else if (ctl.loadCap) begin
      capFlags   <= vioStb;
      capSpid    <= vioSpid;
      capPortVec <= vioPortVec;
      capMac     <= vioMac;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resFlags   <= '0;
      resSpid    <= '0;
      resPortVec <= '0;
      resMac     <= '0;
    end else if (ctl.copyOut) begin
      resFlags   <= ctl.copyValid ? capFlags   : '0;
      resSpid    <= ctl.copyValid ? capSpid    : '0;
      resPortVec <= ctl.copyValid ? capPortVec : '0;
      resMac     <= ctl.copyValid ? capMac     : '0;
    end
  end

  a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.copyOut && !ctl.copyValid) |=> (resFlags == '0 && resMac == '0));
  a_r6_cap_held: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.copyValid && !ctl.copyOut) |=> $stable(capMac));
  a_r8_results_held: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.copyOut |=> $stable(resFlags) && $stable(resMac));
endmodule

// File: rtl/vio_capture.sv
module vio_capture
  import vcap_pkg::*;
#(
  parameter int unsigned SPID_W = 4,
  parameter int unsigned NPORT  = 11,
  parameter int unsigned MAC_W  = 48,
  parameter int unsigned OP_W   = 3,
  parameter logic [OP_W-1:0] GET_CLR_OP = 3'd5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [KINDS-1:0]  vioStb,
  input  logic [SPID_W-1:0] vioSpid,
  input  logic [NPORT-1:0]  vioPortVec,
  input  logic [MAC_W-1:0]  vioMac,
  input  logic              cmdStart,
  input  logic [OP_W-1:0]   cmdOp,
  output logic              busy,
  output logic [KINDS-1:0]  resFlags,
  output logic [SPID_W-1:0] resSpid,
  output logic [NPORT-1:0]  resPortVec,
  output logic [MAC_W-1:0]  resMac,
  output logic              irq,
  output logic              overflow
);
  vcapCtl_t ctl;

  vcap_ctrl #(.OP_W(OP_W), .GET_CLR_OP(GET_CLR_OP)) u_ctrl (
    .clk(clk), .rstN(rstN), .vioAny(|vioStb), .cmdStart(cmdStart),
    .cmdOp(cmdOp), .ctl(ctl), .busy(busy), .irq(irq), .overflow(overflow)
  );

  vcap_dpath #(.SPID_W(SPID_W), .NPORT(NPORT), .MAC_W(MAC_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .vioStb(vioStb), .vioSpid(vioSpid),
    .vioPortVec(vioPortVec), .vioMac(vioMac), .resFlags(resFlags),
    .resSpid(resSpid), .resPortVec(resPortVec), .resMac(resMac)
  );
endmodule

// File: tb/test_vio_capture.sv
module test_vio_capture;
  localparam int NP = 11;
  localparam logic [2:0] GC = 3'd5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] vioStb = '0;
  logic [3:0] vioSpid = '0;
  logic [NP-1:0] vioPortVec = '0;
  logic [47:0] vioMac = '0;
  logic cmdStart = 1'b0;
  logic [2:0] cmdOp = '0;
  logic busy, irq, overflow;
  logic [3:0] resFlags, resSpid;
  logic [NP-1:0] resPortVec;
  logic [47:0] resMac;

  typedef struct packed {
    logic [3:0] f;
    logic [3:0] s;
    logic [NP-1:0] pv;
    logic [47:0] mac;
  } exp_t;

  exp_t expQ[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic prevBusy = 1'b0;

  always #4 clk = ~clk;

  vio_capture i_vio_capture (
    .clk(clk), .rstN(rstN), .vioStb(vioStb), .vioSpid(vioSpid),
    .vioPortVec(vioPortVec), .vioMac(vioMac), .cmdStart(cmdStart),
    .cmdOp(cmdOp), .busy(busy), .resFlags(resFlags), .resSpid(resSpid),
    .resPortVec(resPortVec), .resMac(resMac), .irq(irq), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare results on the cycle busy falls
  always @(negedge clk) begin
    if (rstN && prevBusy && !busy) begin
      if (expQ.size() == 0) chk("R4 unexpected result", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = expQ.pop_front();
        chk("R4 R3 flags", 64'(resFlags), 64'(e.f));
        chk("R4 spid", 64'(resSpid), 64'(e.s));
        chk("R4 portvec", 64'(resPortVec), 64'(e.pv));
        chk("R4 mac", 64'(resMac), 64'(e.mac));
      end
    end
    prevBusy = busy;
  end

  task automatic strobe(input logic [3:0] k, input logic [3:0] s,
                        input logic [NP-1:0] pv, input logic [47:0] m);
    vioStb = k; vioSpid = s; vioPortVec = pv; vioMac = m;
    @(negedge clk);
    vioStb = '0;
  endtask

  task automatic getClr(input exp_t e, input bit inj, input exp_t injE);
    expQ.push_back(e);
    cmdStart = 1'b1; cmdOp = GC;
    @(negedge clk);
    cmdStart = 1'b0;
    chk("R4 busy high", 64'(busy), 64'd1);
    if (inj) begin
      vioStb = injE.f; vioSpid = injE.s; vioPortVec = injE.pv; vioMac = injE.mac;
    end
    @(negedge clk);
    vioStb = '0;
    chk("R4 busy one cycle", 64'(busy), 64'd0);
    chk(inj ? "R9 irq new pending" : "R5 irq low", 64'(irq), 64'(inj));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<20000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    exp_t z, e1, e2;
    z = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 64'(irq), 0);
    chk("R1 busy", 64'(busy), 0);
    chk("R1 overflow", 64'(overflow), 0);
    chk("R1 results", 64'(resFlags) | 64'(resSpid) | 64'(resMac), 0);

    // R2: single member violation
    chk("R2 irq before", 64'(irq), 0);
    strobe(4'b0010, 4'd3, 11'h005, 48'h0011_2233_4455);
    chk("R2 irq raised", 64'(irq), 1);
    e1 = '{f:4'b0010, s:4'd3, pv:11'h005, mac:48'h0011_2233_4455};
    getClr(e1, 1'b0, z);
    repeat (2) @(negedge clk);
    chk("R5 irq stays low", 64'(irq), 0);

    // R3: age-out, miss, full in one cycle
    strobe(4'b1101, 4'd7, 11'h7f0, 48'hA0B0_C0D0_E0F0);
    e1 = '{f:4'b1101, s:4'd7, pv:11'h7f0, mac:48'hA0B0_C0D0_E0F0};
    getClr(e1, 1'b0, z);

    // R9: strobe in completion cycle becomes new pending, no overflow
    strobe(4'b0100, 4'd9, 11'h001, 48'h1111_1111_1111);
    e1 = '{f:4'b0100, s:4'd9, pv:11'h001, mac:48'h1111_1111_1111};
    e2 = '{f:4'b1000, s:4'd12, pv:11'h400, mac:48'h2222_3333_4444};
    getClr(e1, 1'b1, e2);
    chk("R9 no overflow", 64'(overflow), 0);
    getClr(e2, 1'b0, z);

    // R6: second violation dropped, overflow sticky
    strobe(4'b0100, 4'd1, 11'h002, 48'hBEEF_0000_0001);
    strobe(4'b1000, 4'd2, 11'h004, 48'hBEEF_0000_0002);
    chk("R6 overflow set", 64'(overflow), 1);
    e1 = '{f:4'b0100, s:4'd1, pv:11'h002, mac:48'hBEEF_0000_0001};
    getClr(e1, 1'b0, z);
    chk("R6 overflow sticky", 64'(overflow), 1);

    // R7: nothing pending returns zeros
    getClr(z, 1'b0, z);

    // R8: foreign op ignored
    strobe(4'b0001, 4'd5, 11'h0aa, 48'hCAFE_F00D_0001);
    cmdStart = 1'b1; cmdOp = 3'd2;
    @(negedge clk);
    cmdStart = 1'b0;
    chk("R8 busy stays low", 64'(busy), 0);
    @(negedge clk);
    chk("R8 irq unchanged", 64'(irq), 1);
    chk("R8 results unchanged", 64'(resFlags) | 64'(resMac), 0);
    e1 = '{f:4'b0001, s:4'd5, pv:11'h0aa, mac:48'hCAFE_F00D_0001};
    getClr(e1, 1'b0, z);

    @(negedge clk);
    chk("R4 scoreboard drained", 64'(expQ.size()), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule